// File: doc/BRIEF.md
# Per-Pixel Gaussian Mixture Background Updater

This block is a fixed-latency datapath for background subtraction on a stream of grey-scale pixels. Each transfer presents one 8-bit luminance sample together with the stored statistical model of that pixel. The model is a mixture of three Gaussians, and each Gaussian carries a weight, a mean, a variance code and a match counter. The block returns the revised model and a one-bit background flag. Frame storage sits outside the block. The caller reads the model from frame storage, feeds it in with the pixel, and writes the returned model back.

Inside, each Gaussian is first tested for a match. Its deviation comes from a four-segment linear approximation of the square root of its variance. The Gaussians are then ranked by an inverse-fitness key. That key is the deviation shifted left by a power-of-two amount read off the weight, so ranking needs no divider and no multiplier. The best-ranked matching Gaussian learns toward the pixel. If nothing matches, the worst-ranked Gaussian is replaced, and its new weight comes from a piecewise-linear reciprocal. Every Gaussian that is not touched in either way has its weight decayed. Finally, a cumulative-weight test in rank order decides whether the pixel is background.

Top module: `gmm_bg_updater`

## Requirements
- R1: The model is 99 bits wide. Gaussian k sits in bits [33k+32:33k], with the weight in [32:25], the mean in [24:17], the variance code in [16:6] and the counter in [5:0]. The weight is w/256, the variance is 8 times the code, and the mean is in pixel units. `out_valid` rises exactly three rising edges after the edge that samples `in_valid`=1. Each input produces exactly one output, and inputs may arrive back to back.
- R2: While `rst` is high, and after it is released until valid data arrives, `out_valid` is 0.
- R3: The deviation sd is computed from the variance code v as follows: 2+(v>>1) when v<16; 6+(v>>2) when v<64; 14+(v>>3) when v<256; and 30+(v>>4) otherwise.
- R4: Gaussian k matches when 2·|pixel−mean| < 5·sd.
- R5: Let lg be the index of the top set bit of the weight, plus 1 if the bit just below it is also set, with lg=0 for weight 0. The learning shift is s = max(0, ALPHA_SH+lg−8). The inverse fitness is sd<<(8−lg). Ranks run from 0 upward in increasing inverse fitness, and ties go to the lower index. The matching Gaussian with the lowest rank is the one updated.
- R6: For the updated Gaussian, with d = pixel−mean, the new mean is mean+(d>>>s). The new variance code is v+(((d²)>>3)−v)>>>s, clamped to the range 1..2047. Both shifts floor.
- R7: For the updated Gaussian, the weight becomes w+((256−w)>>ALPHA_SH), saturating at 255. The counter increments and saturates at 63.
- R8: Every Gaussian that is neither updated nor replaced keeps its mean, variance and counter, and its weight becomes w−(w>>ALPHA_SH).
- R9: When no Gaussian matches, the rank-2 Gaussian is replaced. It takes mean = pixel, counter = 1 and variance code = VAR_INIT (default 128).
- R10: The replacement weight comes from m, the sum of the other two counters, limited to 1..63. The weight is 383−(m<<7) for m≤2, 105−(m<<3) for m≤7, 40−m for m≤23, and 14−(m>>3) otherwise.
- R11: A Gaussian belongs to the background set when the sum of the input weights of all lower-ranked Gaussians is ≤ BG_THRESH (default 179). `out_bg`=1 when the pixel matches a Gaussian in that set.
- R12: A pixel that matches no Gaussian gives `out_bg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel and model are valid this cycle |
| in_pix | input | 8 | Luminance sample |
| in_model | input | 99 | Stored three-Gaussian model |
| out_valid | output | 1 | Result valid |
| out_bg | output | 1 | 1 = background, 0 = foreground |
| out_model | output | 99 | Updated model |

## Verification
The block holds no state across pixels beyond its pipeline registers. A wrong deviation segment, shift amount, rank or role therefore appears in the `out_model` or `out_bg` of that same sample, three edges after it enters. A lost or duplicated valid shows as a misaligned output during back-to-back streaming. Directed cases aim at the segment edges of both approximations, ties in inverse fitness, the threshold edge of the background test and every saturation and clamp. A stream of varied samples is then compared against a model computed from the requirements.

// File: rtl/gmm_pkg.sv
package gmm_pkg;
    localparam int NG      = 3;
    localparam int PIX_W   = 8;
    localparam int W_W     = 8;
    localparam int VAR_W   = 11;
    localparam int CNT_W   = 6;
    localparam int SD_W    = 8;
    localparam int SH_W    = 4;
    localparam int RANK_W  = 2;
    localparam int IF_W    = SD_W + W_W;
    localparam int GW      = W_W + PIX_W + VAR_W + CNT_W;
    localparam int MODEL_W = NG * GW;

    typedef struct packed {
        logic [W_W-1:0]   w;
        logic [PIX_W-1:0] mean;
        logic [VAR_W-1:0] vr;
        logic [CNT_W-1:0] cnt;
    } gauss_t;

    // what the update stage does to one Gaussian
    typedef enum logic [1:0] {
        ROLE_KEEP = 2'd0,
        ROLE_HIT  = 2'd1,
        ROLE_SWAP = 2'd2
    } role_t;
endpackage

// File: rtl/gmm_gauss_eval.sv
module gmm_gauss_eval
    import gmm_pkg::*;
#(
    parameter int ALPHA_SH = 5
) (
    input  logic [PIX_W-1:0] pix,
    input  gauss_t           g,
    output logic [SD_W-1:0]  sd,
    output logic [IF_W-1:0]  ifit,
    output logic [SH_W-1:0]  shamt,
    output logic             hit
);
    logic [3:0]       msb;
    logic [3:0]       lg;
    logic [PIX_W:0]   d;
    logic [PIX_W-1:0] ad;
    logic [PIX_W+2:0] lhs;
    logic [PIX_W+2:0] rhs;

    // rounded log2 of the weight
    always_comb begin
        msb = '0;
        for (int i = 0; i < W_W; i++)
            if (g.w[i]) msb = 4'(i);
        if (g.w == '0)
            lg = '0;
        else if (msb != 4'd0 && g.w[3'(msb - 4'd1)])
            lg = msb + 4'd1;
        else
            lg = msb;
    end

    always_comb begin
        int t;
        t = ALPHA_SH + int'(lg) - W_W;
        shamt = (t < 0) ? '0 : SH_W'(t);
    end

    // four-segment square root of 8*v
    always_comb begin
        if (g.vr < 11'd16)       sd = SD_W'(2  + (g.vr >> 1));
        else if (g.vr < 11'd64)  sd = SD_W'(6  + (g.vr >> 2));
        else if (g.vr < 11'd256) sd = SD_W'(14 + (g.vr >> 3));
        else                     sd = SD_W'(30 + (g.vr >> 4));
    end

    assign ifit = IF_W'(sd) << (4'd8 - lg);

    always_comb begin
        d   = {1'b0, pix} - {1'b0, g.mean};
        ad  = d[PIX_W] ? PIX_W'(-d) : PIX_W'(d);
        lhs = (PIX_W+3)'({ad, 1'b0});
        rhs = {1'b0, sd, 2'b00} + (PIX_W+3)'(sd);
        hit = lhs < rhs;
    end
endmodule

// File: rtl/gmm_rank.sv
module gmm_rank
    import gmm_pkg::*;
(
    input  logic [NG-1:0][IF_W-1:0]   ifit,
    output logic [NG-1:0][RANK_W-1:0] rank
);
    always_comb begin
        for (int k = 0; k < NG; k++) begin
            rank[k] = '0;
            for (int j = 0; j < NG; j++)
                if (j != k && (ifit[j] < ifit[k] || (ifit[j] == ifit[k] && j < k)))
                    rank[k] = rank[k] + 1'b1;
        end
    end
endmodule

// File: rtl/gmm_recip.sv
module gmm_recip
    import gmm_pkg::*;
(
    input  logic [CNT_W-1:0] m,
    output logic [W_W-1:0]   z
);
    logic [9:0] mx;

    always_comb begin
        mx = 10'(m);
        if (m <= CNT_W'(2))       z = W_W'(10'd383 - (mx << 7));
        else if (m <= CNT_W'(7))  z = W_W'(10'd105 - (mx << 3));
        else if (m <= CNT_W'(23)) z = W_W'(10'd40 - mx);
        else                      z = W_W'(10'd14 - (mx >> 3));
    end
endmodule

// File: rtl/gmm_update.sv
module gmm_update
    import gmm_pkg::*;
#(
    parameter int ALPHA_SH = 5,
    parameter int VAR_INIT = 128
) (
    input  role_t            role,
    input  gauss_t           g,
    input  logic [PIX_W-1:0] pix,
    input  logic [SH_W-1:0]  shamt,
    input  logic [W_W-1:0]   w_new,
    output gauss_t           q
);
    localparam int VMAX = (1 << VAR_W) - 1;
    localparam int EW   = 2 * PIX_W + 2;

    logic signed [PIX_W+1:0] d;
    logic signed [PIX_W+1:0] dm;
    logic [PIX_W-1:0]        ad;
    logic [2*PIX_W-1:0]      dsq;
    logic signed [EW-1:0]    e;
    logic signed [EW-1:0]    vsum;
    logic [W_W:0]            wup;

    always_comb begin
        d    = signed'({2'b00, pix}) - signed'({2'b00, g.mean});
        ad   = d[PIX_W+1] ? PIX_W'(-d) : PIX_W'(d);
        dsq  = (2*PIX_W)'(ad) * (2*PIX_W)'(ad);
        dm   = d >>> shamt;
        e    = signed'(EW'(dsq >> 3)) - signed'(EW'(g.vr));
        vsum = signed'(EW'(g.vr)) + (e >>> shamt);
        wup  = (W_W+1)'(g.w) + (((W_W+1)'(1 << W_W) - (W_W+1)'(g.w)) >> ALPHA_SH);

        q = g;
        unique case (role)
            ROLE_HIT: begin
                q.mean = PIX_W'(signed'({2'b00, g.mean}) + dm);
                if (vsum < 1)         q.vr = VAR_W'(1);
                else if (vsum > VMAX) q.vr = VAR_W'(VMAX);
                else                  q.vr = VAR_W'(vsum);
                q.w   = wup[W_W] ? '1 : wup[W_W-1:0];
                q.cnt = (g.cnt == '1) ? g.cnt : g.cnt + 1'b1;
            end
            ROLE_SWAP: begin
                q.w    = w_new;
                q.mean = pix;
                q.vr   = VAR_W'(VAR_INIT);
                q.cnt  = CNT_W'(1);
            end
            default: q.w = g.w - (g.w >> ALPHA_SH);
        endcase
    end
endmodule

// File: rtl/gmm_bg_updater.sv
module gmm_bg_updater
    import gmm_pkg::*;
#(
    parameter int ALPHA_SH  = 5,
    parameter int BG_THRESH = 179,
    parameter int VAR_INIT  = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_pix,
    input  logic [MODEL_W-1:0] in_model,
    output logic               out_valid,
    output logic               out_bg,
    output logic [MODEL_W-1:0] out_model
);
    localparam int SUM_W = W_W + 2;

    // stage 0: input register
    logic               v0;
    logic [PIX_W-1:0]   pix0;
    logic [MODEL_W-1:0] model0;
    // stage 1: evaluated and ranked
    logic               v1;
    logic [PIX_W-1:0]   pix1;
    logic [MODEL_W-1:0] model1;
    logic [NG-1:0]      hit_a, hit1;
    logic [NG-1:0][SH_W-1:0]   sh_a, sh1;
    logic [NG-1:0][SD_W-1:0]   sd_a;
    logic [NG-1:0][IF_W-1:0]   if_a;
    logic [NG-1:0][RANK_W-1:0] rank_a, rank1;

    gauss_t g0 [NG];
    gauss_t g1 [NG];
    gauss_t gq [NG];
    role_t  role [NG];
    logic [MODEL_W-1:0] model_nx;
    logic [CNT_W:0]     msum_raw;
    logic [CNT_W-1:0]   msum;
    logic [W_W-1:0]     w_new;
    logic               any_hit;
    logic               bg_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            v0 <= 1'b0;
            v1 <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v0 <= in_valid;
            v1 <= v0;
            out_valid <= v1;
        end
    end

    always_ff @(posedge clk) begin
        pix0      <= in_pix;
        model0    <= in_model;
        pix1      <= pix0;
        model1    <= model0;
        hit1      <= hit_a;
        sh1       <= sh_a;
        rank1     <= rank_a;
        out_model <= model_nx;
        out_bg    <= bg_nx;
    end

    for (genvar k = 0; k < NG; k++) begin : g_eval
        assign g0[k] = model0[k*GW +: GW];
        assign g1[k] = model1[k*GW +: GW];
        gmm_gauss_eval #(.ALPHA_SH(ALPHA_SH)) eval_i (
            .pix(pix0), .g(g0[k]), .sd(sd_a[k]), .ifit(if_a[k]),
            .shamt(sh_a[k]), .hit(hit_a[k])
        );
    end

    gmm_rank rank_i (.ifit(if_a), .rank(rank_a));

    // stage B: choose roles and run the background test
    always_comb begin
        logic lower_hit;
        logic [SUM_W-1:0] prefix;
        any_hit  = |hit1;
        msum_raw = '0;
        bg_nx    = 1'b0;
        for (int k = 0; k < NG; k++) begin
            lower_hit = 1'b0;
            prefix    = '0;
            for (int j = 0; j < NG; j++) begin
                if (j != k && hit1[j] && rank1[j] < rank1[k]) lower_hit = 1'b1;
                if (rank1[j] < rank1[k]) prefix = prefix + SUM_W'(g1[j].w);
            end
            if (hit1[k] && !lower_hit)
                role[k] = ROLE_HIT;
            else if (!any_hit && rank1[k] == RANK_W'(NG - 1))
                role[k] = ROLE_SWAP;
            else
                role[k] = ROLE_KEEP;
            if (role[k] != ROLE_SWAP) msum_raw = msum_raw + (CNT_W+1)'(g1[k].cnt);
            if (hit1[k] && prefix <= SUM_W'(BG_THRESH)) bg_nx = 1'b1;
        end
        if (msum_raw == '0)               msum = CNT_W'(1);
        else if (msum_raw[CNT_W])         msum = '1;
        else                              msum = msum_raw[CNT_W-1:0];
    end

    gmm_recip recip_i (.m(msum), .z(w_new));

    for (genvar k = 0; k < NG; k++) begin : g_upd
        gmm_update #(.ALPHA_SH(ALPHA_SH), .VAR_INIT(VAR_INIT)) upd_i (
            .role(role[k]), .g(g1[k]), .pix(pix1), .shamt(sh1[k]),
            .w_new(w_new), .q(gq[k])
        );
        assign model_nx[k*GW +: GW] = gq[k];
    end
endmodule

// File: rtl/gmm_bg_chk.sv
module gmm_bg_chk
    import gmm_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic                      out_valid,
    input logic                      v1,
    input logic [PIX_W-1:0]          pix1,
    input logic [MODEL_W-1:0]        model1,
    input logic [MODEL_W-1:0]        out_model,
    input logic [NG-1:0][RANK_W-1:0] rank1
);
    logic [PIX_W-1:0]   pix1_d;
    logic [MODEL_W-1:0] model1_d;
    logic [NG-1:0]      at_first, at_mid, cnt_moved;

    always_ff @(posedge clk) begin
        pix1_d   <= pix1;
        model1_d <= model1;
    end

    for (genvar k = 0; k < NG; k++) begin : g_k
        localparam int B = k * GW;
        logic [PIX_W-1:0] m_old, m_new, lo, hi;
        assign at_first[k]  = (rank1[k] == RANK_W'(0));
        assign at_mid[k]    = (rank1[k] == RANK_W'(1));
        assign cnt_moved[k] = out_model[B +: CNT_W] != model1_d[B +: CNT_W];
        assign m_old = model1_d[B + CNT_W + VAR_W +: PIX_W];
        assign m_new = out_model[B + CNT_W + VAR_W +: PIX_W];
        assign lo = (m_old < pix1_d) ? m_old : pix1_d;
        assign hi = (m_old < pix1_d) ? pix1_d : m_old;

        // R6 / R9: a new mean never leaves the span between old mean and pixel
        assert_mean_span_R6: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (m_new >= lo && m_new <= hi))
            else $error("new mean outside span");
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 3))
        else $error("valid latency broken");

    assert_rank_perm_R5: assert property (@(posedge clk) disable iff (rst)
        v1 |-> ($countones(at_first) == 1 && $countones(at_mid) == 1))
        else $error("ranks are not a permutation");

    assert_one_counter_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(cnt_moved) <= 1)
        else $error("more than one counter changed");
endmodule

bind gmm_bg_updater gmm_bg_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .v1(v1), .pix1(pix1), .model1(model1), .out_model(out_model), .rank1(rank1)
);

// File: tb/gmm_bg_updater_tb.sv
`timescale 1ns/1ps
module gmm_bg_updater_tb_top;
    localparam int A  = 5;
    localparam int T  = 179;
    localparam int VI = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_pix = '0;
    logic [98:0] in_model = '0;
    logic        out_valid, out_bg;
    logic [98:0] out_model;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    gmm_bg_updater #(.ALPHA_SH(A), .BG_THRESH(T), .VAR_INIT(VI)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix), .in_model(in_model),
        .out_valid(out_valid), .out_bg(out_bg), .out_model(out_model)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [32:0] mk(input int w, input int mu, input int v, input int c);
        return {8'(w), 8'(mu), 11'(v), 6'(c)};
    endfunction

    function automatic int fld(input bit [98:0] m, input int k, input int lsb, input int wd);
        return int'((m >> (k*33 + lsb)) & ((99'(1) << wd) - 1));
    endfunction

    function automatic int recip(input int m);
        if (m <= 2) return 383 - (m << 7);
        if (m <= 7) return 105 - (m << 3);
        if (m <= 23) return 40 - m;
        return 14 - (m >> 3);
    endfunction

    // expected result built from the requirements
    function automatic void ref_run(input bit [7:0] pix, input bit [98:0] m,
                                    output bit [98:0] q, output bit bg);
        int w[3], mu[3], v[3], c[3], lg[3], s[3], sd[3], fi[3], rk[3], d[3];
        bit hit[3];
        int bestk, swapk, ms, msb, e, vn, wn, pre;
        bit anyh;
        for (int k = 0; k < 3; k++) begin
            w[k] = fld(m, k, 25, 8); mu[k] = fld(m, k, 17, 8);
            v[k] = fld(m, k, 6, 11); c[k] = fld(m, k, 0, 6);
            if (w[k] == 0) lg[k] = 0;
            else begin
                msb = 0;
                for (int i = 0; i < 8; i++) if ((w[k] >> i) & 1) msb = i;
                lg[k] = msb + ((msb > 0 && ((w[k] >> (msb-1)) & 1)) ? 1 : 0);
            end
            s[k] = A + lg[k] - 8; if (s[k] < 0) s[k] = 0;
            if (v[k] < 16) sd[k] = 2 + (v[k] >> 1);
            else if (v[k] < 64) sd[k] = 6 + (v[k] >> 2);
            else if (v[k] < 256) sd[k] = 14 + (v[k] >> 3);
            else sd[k] = 30 + (v[k] >> 4);
            fi[k] = sd[k] << (8 - lg[k]);
            d[k] = int'(pix) - mu[k];
            hit[k] = 2 * (d[k] < 0 ? -d[k] : d[k]) < 5 * sd[k];
        end
        anyh = 0;
        for (int k = 0; k < 3; k++) begin
            rk[k] = 0;
            for (int j = 0; j < 3; j++)
                if (j != k && (fi[j] < fi[k] || (fi[j] == fi[k] && j < k))) rk[k]++;
            anyh |= hit[k];
        end
        bestk = -1; swapk = -1;
        for (int k = 0; k < 3; k++) begin
            if (hit[k] && (bestk < 0 || rk[k] < rk[bestk])) bestk = k;
            if (!anyh && rk[k] == 2) swapk = k;
        end
        ms = 0;
        for (int k = 0; k < 3; k++) if (k != swapk) ms += c[k];
        if (ms > 63) ms = 63;
        if (ms == 0) ms = 1;
        bg = 0;
        for (int k = 0; k < 3; k++) begin
            pre = 0;
            for (int j = 0; j < 3; j++) if (rk[j] < rk[k]) pre += w[j];
            if (hit[k] && pre <= T) bg = 1;
        end
        for (int k = 0; k < 3; k++) begin
            if (k == bestk) begin
                e  = ((d[k] * d[k]) >> 3) - v[k];
                vn = v[k] + (e >>> s[k]);
                if (vn < 1) vn = 1; if (vn > 2047) vn = 2047;
                wn = w[k] + ((256 - w[k]) >> A); if (wn > 255) wn = 255;
                q[k*33 +: 33] = mk(wn, mu[k] + (d[k] >>> s[k]), vn, c[k] < 63 ? c[k] + 1 : 63);
            end else if (k == swapk) begin
                q[k*33 +: 33] = mk(recip(ms), pix, VI, 1);
            end else begin
                q[k*33 +: 33] = mk(w[k] - (w[k] >> A), mu[k], v[k], c[k]);
            end
        end
    endfunction

    // one isolated sample; R1 latency checked on the way
    task automatic run_one(input bit [7:0] pix, input bit [98:0] m,
                           output bit [98:0] q, output bit bg);
        @(negedge clk);
        in_pix = pix; in_model = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1", "valid early", 128'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid early", 128'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", "valid on time", 128'(out_valid), 1);
        q = out_model; bg = out_bg;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid single", 128'(out_valid), 0);
    endtask

    task automatic run_ref(input string req, input bit [7:0] pix, input bit [98:0] m);
        bit [98:0] q, eq; bit bg, ebg;
        ref_run(pix, m, eq, ebg);
        run_one(pix, m, q, bg);
        check(q == eq, req, "model", 128'(q), 128'(eq));
        check(bg == ebg, req, "bg", 128'(bg), 128'(ebg));
    endtask

    task automatic t_reset;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R2", "valid in reset", 128'(out_valid), 0);
        end
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R2", "valid after reset", 128'(out_valid), 0);
        end
    endtask

    task automatic t_hand_hit;
        bit [98:0] q, eq; bit bg;
        run_one(8'd110, {mk(15,200,32,3), mk(40,50,32,5), mk(200,100,32,10)}, q, bg);
        eq = {mk(15,200,32,3), mk(39,50,32,5), mk(201,100,31,11)};
        check(q[32:0] == eq[32:0], "R6", "hit gaussian", 128'(q[32:0]), 128'(eq[32:0]));
        check(q[98:33] == eq[98:33], "R8", "decayed gaussians", 128'(q[98:33]), 128'(eq[98:33]));
        check(bg == 1'b1, "R11", "bg on hit", 128'(bg), 1);
    endtask

    task automatic t_hand_swap;
        bit [98:0] q, eq; bit bg;
        run_one(8'd250, {mk(15,200,32,3), mk(40,50,32,5), mk(200,100,32,10)}, q, bg);
        eq = {mk(25,250,128,1), mk(39,50,32,5), mk(194,100,32,10)};
        check(q[98:66] == eq[98:66], "R9", "replaced gaussian", 128'(q[98:66]), 128'(eq[98:66]));
        check(q[65:0] == eq[65:0], "R8", "others decayed", 128'(q[65:0]), 128'(eq[65:0]));
        check(bg == 1'b0, "R12", "no match is fg", 128'(bg), 0);
    endtask

    task automatic t_recip_segments;
        int pairs[7][2] = '{'{0,0}, '{1,0}, '{1,1}, '{2,3}, '{10,10}, '{20,20}, '{40,40}};
        int exps[7] = '{255, 255, 127, 65, 20, 9, 7};
        bit [98:0] q; bit bg;
        for (int i = 0; i < 7; i++) begin
            run_one(8'd255, {mk(15,0,32,9), mk(40,0,32,pairs[i][1]), mk(200,0,32,pairs[i][0])}, q, bg);
            check(q[98:91] == 8'(exps[i]), "R10", "reciprocal weight", 128'(q[98:91]), 128'(exps[i]));
        end
    endtask

    task automatic t_rank_order;
        bit [98:0] q; bit bg;
        // identical gaussians: index 0 wins the tie
        run_one(8'd60, {mk(100,60,32,4), mk(100,60,32,4), mk(100,60,32,4)}, q, bg);
        check(q[5:0] == 6'd5 && q[38:33] == 6'd4 && q[71:66] == 6'd4, "R5", "tie to index 0",
              128'({q[71:66], q[38:33], q[5:0]}), 128'({6'd4, 6'd4, 6'd5}));
        // two matches: the fitter index 1 is the one updated
        run_one(8'd101, {mk(10,0,1,2), mk(200,102,32,7), mk(20,100,32,3)}, q, bg);
        check(q[38:33] == 6'd8 && q[5:0] == 6'd3, "R5", "fitter match updated",
              128'({q[38:33], q[5:0]}), 128'({6'd8, 6'd3}));
        run_ref("R5", 8'd101, {mk(10,0,1,2), mk(200,102,32,7), mk(20,100,32,3)});
    endtask

    task automatic t_threshold;
        bit [98:0] q; bit bg;
        run_one(8'd100, {mk(5,250,1,1), mk(100,100,32,2), mk(180,0,32,2)}, q, bg);
        check(bg == 1'b0, "R11", "prefix above threshold", 128'(bg), 0);
        run_one(8'd100, {mk(5,250,1,1), mk(100,100,32,2), mk(179,0,32,2)}, q, bg);
        check(bg == 1'b1, "R11", "prefix at threshold", 128'(bg), 1);
    endtask

    task automatic t_saturation;
        bit [98:0] q; bit bg;
        run_one(8'd100, {mk(1,0,1,0), mk(1,0,1,0), mk(255,100,32,63)}, q, bg);
        check(q[32:25] == 8'd255 && q[5:0] == 6'd63, "R7", "weight and counter saturate",
              128'({q[32:25], q[5:0]}), 128'({8'd255, 6'd63}));
        run_one(8'd255, {mk(8,0,1,0), mk(8,0,1,0), mk(8,0,2047,1)}, q, bg);
        check(q[16:6] == 11'd2047 && q[24:17] == 8'd255, "R6", "variance top clamp",
              128'({q[24:17], q[16:6]}), 128'({8'd255, 11'd2047}));
        run_one(8'd50, {mk(8,200,1,0), mk(8,200,1,0), mk(8,50,1,1)}, q, bg);
        check(q[16:6] == 11'd1, "R6", "variance bottom clamp", 128'(q[16:6]), 1);
    endtask

    task automatic t_segments;
        int vs[8] = '{1, 15, 16, 63, 64, 255, 256, 2047};
        for (int i = 0; i < 8; i++) begin
            // R3/R4 boundary probes, both sides of 2.5 sd
            run_ref("R3", 8'd128, {mk(3,0,1,0), mk(3,0,1,0), mk(150, 128 - (vs[i] < 256 ? 6 + i*4 : 40), vs[i], 2)});
            run_ref("R4", 8'd200, {mk(3,0,1,0), mk(3,0,1,0), mk(60, 200 - (i*8), vs[i], 2)});
        end
    endtask

    task automatic t_stream;
        int n = 40;
        bit [7:0]  px [40];
        bit [98:0] md [40];
        bit [98:0] eq; bit ebg;
        for (int i = 0; i < n; i++) begin
            int p = int'($urandom_range(255));
            px[i] = 8'(p);
            for (int k = 0; k < 3; k++) begin
                int mu = p + int'($urandom_range(80)) - 40;
                if (mu < 0) mu = 0; if (mu > 255) mu = 255;
                md[i][k*33 +: 33] = mk(int'($urandom_range(255)), mu,
                                      1 + int'($urandom_range(400)), int'($urandom_range(63)));
            end
        end
        for (int j = 0; j < n + 3; j++) begin
            @(negedge clk);
            if (j >= 3) begin
                ref_run(px[j-3], md[j-3], eq, ebg);
                check(out_valid == 1'b1, "R1", "stream valid", 128'(out_valid), 1);
                check(out_model == eq, "R1", "stream model", 128'(out_model), 128'(eq));
                check(out_bg == ebg, "R11", "stream bg", 128'(out_bg), 128'(ebg));
            end
            if (j < n) begin
                in_pix = px[j]; in_model = md[j]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_hand_hit();
        t_hand_swap();
        t_recip_segments();
        t_rank_order();
        t_threshold();
        t_saturation();
        t_segments();
        t_stream();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule